// File: doc/BRIEF.md
# Bit-Serial Two's Complement Adder

This block adds two two's complement numbers of any length. The numbers arrive one bit pair per clock, starting with the least significant bit, and the sum leaves the block bit-serially in the same order. The only limit on the length of a number is how long the surrounding controller keeps supplying bits. The same controller starts each new addition by pulsing the reset. It also drops the enable whenever the serial inputs do not hold valid data.

A compile-time parameter selects one of two state-machine styles. The first is a two-state Mealy machine. Its next-state and output logic is a small lookup table, and its sum bit is valid in the same cycle as the operand pair. The second is a four-state Moore machine with one flip-flop per state. Its sum bit depends only on the state, so each sum bit appears one enabled cycle after its operand pair. For the same input stream, both styles produce the same sequence of sum bits.

Top module: `bsa_top`

## Requirements
- R1: Operand bits are taken least significant bit first, one pair at each rising clock edge where `en` is high. Sum bits come out in the same order.
- R2: The sum has exactly as many bits as the operands. The carry out of the top bit is dropped, so an n-bit result is (A+B) mod 2^n.
- R3: When `rst_n` is low at a rising edge, the machine returns to its initial state, which is carry clear. After that edge, the Mealy style holds zero in its state flip-flop. The Moore style holds only the initial-state flip-flop set and drives `sum_bit` low.
- R4: At an edge where `en` is low, the state does not change and the input bits are not consumed. In the Moore style, `sum_bit` also holds its value.
- R5: In the Mealy style (MOORE=0), `sum_bit` is the combinational value `a_bit ^ b_bit ^ carry` of the present inputs and state.
- R6: The Mealy style uses one state flip-flop and an 8-entry lookup table. The table is addressed by {carry, a_bit, b_bit}, and each 2-bit word holds {next carry, sum}.
- R7: In the Moore style (MOORE=1), `sum_bit` depends only on the state. It equals the sum of the operand pair taken at the most recent enabled edge.
- R8: The Moore style uses four states, indexed {carry, sum}, with one flip-flop each. Exactly one of these flip-flops is set at every edge after reset.
- R9: For the same stream of operand bits, both styles produce the same sequence of sum bits.
- R10: The next carry is the majority of `a_bit`, `b_bit` and the current carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset that starts a new addition |
| en | input | 1 | When high, the current operand pair is consumed at the edge |
| a_bit | input | 1 | Serial bit of operand A, least significant bit first |
| b_bit | input | 1 | Serial bit of operand B, least significant bit first |
| sum_bit | output | 1 | Serial sum bit |

## Verification
All eight combinations of carry, A bit and B bit are set up one at a time. In each, the Mealy sum, the carry left behind and the Moore output are checked. A wrong entry in the lookup table or the one-hot decode shows up here and not just as some wrong sum. Fixed operands then separate the plain, no-carry case from a carry that ripples through every bit and from wrap-around at the operand width; a lone low bit catches a reversed bit order. Random lengths and values with gaps in the enable, a reset in the middle of an addition, and a side-by-side comparison of the two styles expose gap handling, carry clearing and any difference in timing between the styles.

// File: rtl/bsa_pkg.sv
// Shared constants and carry/sum helpers for the bit-serial adder.
// Assumes single-bit operand streams; no state is held here.
package bsa_pkg;
    localparam int LUT_AW    = 3;   // address {carry, a, b}
    localparam int LUT_DW    = 2;   // word {next_carry, sum}
    localparam int MOORE_NST = 4;   // states indexed {carry, sum}
    localparam int MOORE_IW  = $clog2(MOORE_NST);

    // Majority of three bits: the carry out of a full adder.
    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

    // One word of the Mealy lookup table for address {carry, a, b}.
    function automatic logic [LUT_DW-1:0] lut_word(input logic [LUT_AW-1:0] ad);
        return {maj3(ad[2], ad[1], ad[0]), ad[2] ^ ad[1] ^ ad[0]};
    endfunction
endpackage

// File: rtl/bsa_lut.sv
// Read-only table holding the Mealy next-state and output function.
// Filled at elaboration from the package helper; purely combinational.
module bsa_lut
    import bsa_pkg::*;
#(
    parameter int AW = LUT_AW,
    parameter int DW = LUT_DW
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] word
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] tbl [DEPTH];

    // One constant entry per address.
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        assign tbl[i] = DW'(lut_word(LUT_AW'(i)));
    end

    // Table read.
    assign word = tbl[addr];
endmodule

// File: rtl/bsa_mealy.sv
// Two-state Mealy serial adder: one carry flip-flop plus a lookup table.
// The sum is valid in the same cycle as the operand pair; en gates the update.
module bsa_mealy
    import bsa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic a_bit,
    input  logic b_bit,
    output logic sum_bit,
    output logic carry_o
);
    logic              carry_q;
    logic [LUT_AW-1:0] addr;
    logic [LUT_DW-1:0] word;

    // Build the table address from the state and the present inputs.
    assign addr = {carry_q, a_bit, b_bit};

    bsa_lut #(.AW(LUT_AW), .DW(LUT_DW)) u_lut (
        .addr(addr),
        .word(word)
    );

    // Output comes straight from the table word.
    assign sum_bit = word[0];
    assign carry_o = carry_q;

    // Carry register: cleared by reset, loaded only on enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n)  carry_q <= 1'b0;
        else if (en) carry_q <= word[1];
    end
endmodule

// File: rtl/bsa_moore.sv
// Four-state Moore serial adder with one flip-flop per state.
// A state is indexed {carry, sum}; the output is decoded from the state alone,
// so each sum bit appears one enabled cycle after its operand pair.
module bsa_moore
    import bsa_pkg::*;
#(
    parameter int NST = MOORE_NST
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           a_bit,
    input  logic           b_bit,
    output logic           sum_bit,
    output logic [NST-1:0] oh_q
);
    localparam int IW = MOORE_IW;
    localparam logic [NST-1:0] INIT = NST'(1);

    logic           carry;
    logic [IW-1:0]  tgt;
    logic [NST-1:0] nxt;

    // Decode carry and sum from the active state.
    assign carry   = oh_q[2] | oh_q[3];
    assign sum_bit = oh_q[1] | oh_q[3];

    // Index of the state to enter on an enabled edge.
    assign tgt = {maj3(a_bit, b_bit, carry), a_bit ^ b_bit ^ carry};

    // One next-state bit per state flip-flop.
    for (genvar i = 0; i < NST; i++) begin : g_next
        assign nxt[i] = en ? (tgt == IW'(i)) : oh_q[i];
    end

    // State register: reset selects only the initial state.
    always_ff @(posedge clk) begin
        if (!rst_n) oh_q <= INIT;
        else        oh_q <= nxt;
    end
endmodule

// File: rtl/bsa_top.sv
// Bit-serial two's complement adder, top level.
// MOORE=0 builds the lookup-table Mealy machine and MOORE=1 the one-hot Moore
// machine. Reset and enable come from an external controller.
module bsa_top
    import bsa_pkg::*;
#(
    parameter bit MOORE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic a_bit,
    input  logic b_bit,
    output logic sum_bit
);
    localparam int ST_W = MOORE_NST;

    logic [ST_W-1:0] st_vec;   // state view used by the bound checker

    if (MOORE) begin : g_moore
        bsa_moore #(.NST(ST_W)) u_core (
            .clk(clk), .rst_n(rst_n), .en(en),
            .a_bit(a_bit), .b_bit(b_bit),
            .sum_bit(sum_bit), .oh_q(st_vec)
        );
    end else begin : g_mealy
        logic carry;
        bsa_mealy u_core (
            .clk(clk), .rst_n(rst_n), .en(en),
            .a_bit(a_bit), .b_bit(b_bit),
            .sum_bit(sum_bit), .carry_o(carry)
        );
        // Pad the one-bit state to the common view width.
        assign st_vec = {{(ST_W-1){1'b0}}, carry};
    end
endmodule

// File: rtl/bsa_chk.sv
// Assertion checker for bsa_top, attached with bind below.
// Relates the ports to the state view over time for the selected style.
module bsa_chk #(
    parameter bit MOORE = 1'b0,
    parameter int ST_W  = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en,
    input logic            a_bit,
    input logic            b_bit,
    input logic            sum_bit,
    input logic [ST_W-1:0] st
);
    localparam logic [ST_W-1:0] INIT = MOORE ? ST_W'(1) : '0;

    // Reset lands in the initial state (R3).
    p_init_r3: assert property (@(posedge clk) !rst_n |=> st == INIT);

    // Disabled edges leave the state unchanged (R4).
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(st));

    if (MOORE) begin : g_moore
        // Exactly one state flip-flop is set (R8).
        p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(st) == 1);
        // The output shows the previous enabled pair's sum (R7).
        p_sum_late_r7: assert property (@(posedge clk) disable iff (!rst_n)
            en |=> sum_bit == ($past(a_bit) ^ $past(b_bit) ^ $past(st[2] | st[3])));
        // The output holds across a disabled edge (R4).
        p_out_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !en |=> $stable(sum_bit));
        // The output is low right after reset (R3).
        p_init_out_r3: assert property (@(posedge clk) !rst_n |=> !sum_bit);
    end else begin : g_mealy
        // The sum follows the present inputs and carry (R5).
        p_sum_now_r5: assert property (@(posedge clk) disable iff (!rst_n)
            sum_bit == (a_bit ^ b_bit ^ st[0]));
        // The carry updates to the majority value (R10).
        p_carry_maj_r10: assert property (@(posedge clk) disable iff (!rst_n)
            en |=> st[0] == (($past(a_bit) & $past(b_bit)) |
                             ($past(a_bit) & $past(st[0])) |
                             ($past(b_bit) & $past(st[0]))));
    end
endmodule

bind bsa_top bsa_chk #(.MOORE(MOORE), .ST_W(ST_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .a_bit(a_bit), .b_bit(b_bit),
    .sum_bit(sum_bit), .st(st_vec)
);

// File: tb/sim_bsa_top.sv
// Directed bench: u0 is the Mealy style and u1 the Moore style, both fed the same streams.
module sim_bsa_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic a = 1'b0;
    logic b = 1'b0;
    logic s_me, s_mo;
    int   total = 0;
    int   bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    bsa_top #(.MOORE(1'b0)) u0 (.clk(clk), .rst_n(rst_n), .en(en),
        .a_bit(a), .b_bit(b), .sum_bit(s_me));
    bsa_top #(.MOORE(1'b1)) u1 (.clk(clk), .rst_n(rst_n), .en(en),
        .a_bit(a), .b_bit(b), .sum_bit(s_mo));

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Pulse reset with random enable and data, then check the initial state (R3).
    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0; en = 1'($urandom); a = 1'($urandom); b = 1'($urandom);
        @(negedge clk);
        rst_n = 1'b1; en = 1'b0;
        chk(s_mo == 1'b0, "R3 moore output low after reset", 64'(s_mo), 64'd0);
        a = 1'b1; b = 1'b0; #1;
        chk(s_me == 1'b1, "R3 mealy carry clear after reset", 64'(s_me), 64'd1);
        a = 1'b1; b = 1'b1; #1;
        chk(s_me == 1'b0, "R5 mealy 1+1 with no carry", 64'(s_me), 64'd0);
    endtask

    // Feed one addition of len bits with random enable gaps; compare both styles.
    task automatic run_op(input int len, input logic [63:0] av, input logic [63:0] bv,
                          input int gap_max, input string tag);
        logic [63:0] rm = '0;
        logic [63:0] ro = '0;
        logic [63:0] mask, exp;
        logic prev;
        mask = (len >= 64) ? '1 : ((64'd1 << len) - 64'd1);
        exp  = (av + bv) & mask;
        for (int i = 0; i < len; i++) begin
            int gaps = (gap_max > 0) ? int'($urandom_range(0, gap_max)) : 0;
            for (int g = 0; g < gaps; g++) begin
                en = 1'b0; a = 1'($urandom); b = 1'($urandom);
                prev = s_mo;
                @(negedge clk);
                chk(s_mo == prev, "R4 moore output held during gap", 64'(s_mo), 64'(prev));
            end
            en = 1'b1; a = av[i]; b = bv[i];
            #1 rm[i] = s_me;
            @(negedge clk);
            ro[i] = s_mo;
            en = 1'b0;
        end
        chk(rm == exp, {"R1 R2 mealy sum ", tag}, rm, exp);
        chk(ro == exp, {"R7 moore sum ", tag}, ro, exp);
        chk(rm == ro, {"R9 styles agree ", tag}, rm, ro);
    endtask

    // Set up every {carry,a,b}; check the table sum, the carry left behind and the Moore state (R6 R10 R7 R8).
    task automatic t_table;
        for (int c = 0; c < 2; c++) begin
            for (int ab = 0; ab < 4; ab++) begin
                logic xa, xb, es, ec;
                t_reset();
                if (c == 1) begin
                    en = 1'b1; a = 1'b1; b = 1'b1;
                    @(negedge clk);
                    en = 1'b0;
                end
                xa = 1'(ab >> 1); xb = 1'(ab);
                es = xa ^ xb ^ 1'(c);
                ec = (xa & xb) | (xa & 1'(c)) | (xb & 1'(c));
                a = xa; b = xb; #1;
                chk(s_me == es, "R6 table sum word", 64'(s_me), 64'(es));
                en = 1'b1;
                @(negedge clk);
                en = 1'b0; a = 1'b0; b = 1'b0; #1;
                chk(s_me == ec, "R10 majority carry", 64'(s_me), 64'(ec));
                chk(s_mo == es, "R7 R8 moore state shows sum", 64'(s_mo), 64'(es));
            end
        end
    endtask

    // Fixed operands: no carry, full ripple with wrap, signed edge, single bit, bit order.
    task automatic t_directed;
        t_reset(); run_op(8, 64'h00, 64'h00, 0, "zeros");
        t_reset(); run_op(16, 64'hFFFF, 64'h0001, 0, "R2 wrap -1+1");
        t_reset(); run_op(8, 64'h7F, 64'h01, 0, "max+1");
        t_reset(); run_op(1, 64'h1, 64'h1, 0, "one bit");
        t_reset(); run_op(4, 64'h1, 64'h0, 0, "R1 lsb first");
        t_reset(); run_op(64, '1, '1, 0, "64 bit -1-1");
    endtask

    // Random operands with gaps on the enable (R4).
    task automatic t_gaps;
        for (int k = 0; k < 10; k++) begin
            t_reset();
            run_op(12, {$urandom, $urandom}, {$urandom, $urandom}, 3, "R4 gaps");
        end
    endtask

    // Reset in the middle of an addition must clear a pending carry (R3).
    task automatic t_midreset;
        t_reset();
        en = 1'b1; a = 1'b1; b = 1'b1;
        @(negedge clk);
        en = 1'b0;
        t_reset();
        run_op(8, 64'h01, 64'h01, 0, "R3 after mid reset");
    endtask

    // Random lengths and values.
    task automatic t_random;
        for (int k = 0; k < 40; k++) begin
            int len = int'($urandom_range(1, 64));
            t_reset();
            run_op(len, {$urandom, $urandom}, {$urandom, $urandom}, 2, "random");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_table();
        t_directed();
        t_gaps();
        t_midreset();
        t_random();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule